// File: doc/BRIEF.md
# Two-Stage Card Clock Generator

This block derives the card clocks for two card slots from a single fast reference clock. A first-stage integer divider sets a base period and a high time. A bank of second-stage dividers then divides that base clock by an even factor, or passes it through unchanged. Each slot picks one second-stage divider as its source and gates it with its own enable and low-power controls. Every output is a register clocked by the reference clock.

Software programs staging registers through a simple write/read strobe port. None of these values reach the running clocks until a start bit is set. The block takes the staged values into its shadow registers at a point where no high pulse can be cut short, and then clears the start bit. A second start issued while one is still pending sets a sticky lock error and is dropped.

Top module: `cclk_gen`

## Requirements
- R1: With first-stage fields per (address 0, bits [3:0]) and hi (bits [7:4]), the base clock has a period of P+1 reference cycles and is high for H+1 cycles. P equals per, except that per=0 is treated as 1. H equals hi, except that hi is limited to P-1.
- R2: The second-stage divider k has its factor M in address 1, bits [8k+7:8k]. When M is nonzero, its output is high for M base periods and low for M base periods, and each high phase begins together with a base-clock high phase.
- R3: A second-stage divider with M=0 passes the base clock through unchanged.
- R4: The slot configuration register is address 2. The source of slot s sits in bits [16+2s+1:16+2s], and each slot's card clock follows the divider that its own field selects.
- R5: Enable bit s of address 2 set to 0 holds card_clk[s] low.
- R6: With low-power bit 8+s of address 2 set, card_clk[s] stays low while slot_busy[s] is 0 and runs while slot_busy[s] is 1.
- R7: Writing 1 to bit 0 of address 3 requests a commit. Bit 0 reads 1 on the first read after the request and returns to 0 once the block has taken the staged values.
- R8: Writes to addresses 0 to 2 that are not followed by a start request leave the card clocks unchanged, but they can be read back.
- R9: A start request made while the previous one is still pending sets the lock error (bit 1 of address 3). The extra request is dropped, and the flag stays set after the pending commit completes.
- R10: Writing 1 to bit 1 of address 3, with bit 0 at 0, clears the lock error.
- R11: A commit happens only in the last cycle of a base period, when the base clock and every active divided clock are low. A card clock rises only one cycle after its selected source was high.
- R12: After reset, both card clocks are low and every register reads 0. reg_rdata returns the addressed register one cycle after reg_rd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| slot_busy | input | 2 | Per-slot activity indication used by low-power gating |
| card_clk | output | 2 | Per-slot card clock |

## Verification
Read data arrives one cycle after the read strobe, so the bench samples reg_rdata at the falling edge that follows the strobe edge. The delay from a start request to its commit depends on the phases of the base and divided clocks. For that reason the bench polls the pending bit and does not assume a fixed cycle count. A card clock follows its source one register later. The bench therefore measures high and low run lengths at falling edges, skips the first pulse after a commit, and compares the second pulse with the widths computed from the requirements, so the fixed latency does not affect the result.

// File: rtl/cclk_pkg.sv
package cclk_pkg;
  typedef enum logic [1:0] {
    REG_STAGE1 = 2'd0,
    REG_STAGE2 = 2'd1,
    REG_SLOT   = 2'd2,
    REG_CTRL   = 2'd3
  } reg_addr_e;

  localparam int CTRL_START_BIT = 0;
  localparam int CTRL_LOCK_BIT  = 1;
  localparam int SLOT_LP_BASE   = 8;
  localparam int SLOT_SEL_BASE  = 16;
endpackage

// File: rtl/cclk_stage1.sv
module cclk_stage1 #(
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] per,
  input  logic [PW-1:0] high,
  output logic          clk1,
  output logic          last
);
  logic [PW-1:0] cnt;
  logic [PW-1:0] cnt_nxt;

  assign last    = (cnt >= per);
  assign cnt_nxt = last ? '0 : cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= PW'(1);
      clk1 <= 1'b0;
    end else begin
      cnt  <= cnt_nxt;
      clk1 <= (cnt_nxt <= high);
    end
  end
endmodule

// File: rtl/cclk_stage2.sv
module cclk_stage2 #(
  parameter int MW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rise,
  input  logic          commit,
  input  logic [MW-1:0] m,
  input  logic          clk1,
  output logic          div,
  output logic          low_ok
);
  logic [MW-1:0] cnt;
  logic          tog;
  logic          bypass;

  assign bypass = (m == '0);
  assign div    = bypass ? clk1 : tog;
  assign low_ok = bypass | ~tog;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      tog <= 1'b0;
    end else if (commit) begin
      cnt <= '0;
      tog <= 1'b1;
    end else if (rise && !bypass) begin
      if (cnt == m - 1'b1) begin
        cnt <= '0;
        tog <= ~tog;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cclk_slot_gate.sv
module cclk_slot_gate #(
  parameter int NDIV = 4,
  parameter int SELW = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NDIV-1:0] div,
  input  logic [SELW-1:0] sel,
  input  logic            en,
  input  logic            lp,
  input  logic            busy,
  output logic            src,
  output logic            card
);
  logic gate;

  assign src = div[sel];

  always_ff @(posedge clk) begin
    if (rst) begin
      gate <= 1'b0;
      card <= 1'b0;
    end else begin
      if (!src) gate <= en & (~lp | busy);
      card <= src & gate;
    end
  end
endmodule

// File: rtl/cclk_regs.sv
module cclk_regs
  import cclk_pkg::*;
#(
  parameter int NSLOT = 2,
  parameter int NDIV  = 4,
  parameter int PW    = 4,
  parameter int MW    = 8,
  parameter int SELW  = 2,
  parameter int DW    = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic [1:0]            reg_addr,
  input  logic [DW-1:0]         reg_wdata,
  output logic [DW-1:0]         reg_rdata,
  input  logic                  safe,
  output logic                  commit,
  output logic                  pending,
  output logic                  lock_err,
  output logic [PW-1:0]         sh_p,
  output logic [PW-1:0]         sh_h,
  output logic [NDIV*MW-1:0]    sh_m,
  output logic [NSLOT-1:0]      sh_en,
  output logic [NSLOT-1:0]      sh_lp,
  output logic [NSLOT*SELW-1:0] sh_sel
);
  logic [PW-1:0]         stg_p, stg_h;
  logic [NDIV*MW-1:0]    stg_m;
  logic [NSLOT-1:0]      stg_en, stg_lp;
  logic [NSLOT*SELW-1:0] stg_sel;
  logic [PW-1:0]         eff_p, eff_h;
  logic                  ctrl_wr, start_req;
  logic [DW-1:0]         rd_mux;

  assign ctrl_wr   = reg_wr && (reg_addr == REG_CTRL);
  assign start_req = ctrl_wr && reg_wdata[CTRL_START_BIT];
  assign commit    = pending && safe;
  assign eff_p     = (stg_p == '0) ? PW'(1) : stg_p;
  assign eff_h     = (stg_h >= eff_p) ? eff_p - 1'b1 : stg_h;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_p   <= '0;
      stg_h   <= '0;
      stg_m   <= '0;
      stg_en  <= '0;
      stg_lp  <= '0;
      stg_sel <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        REG_STAGE1: begin
          stg_p <= reg_wdata[PW-1:0];
          stg_h <= reg_wdata[2*PW-1:PW];
        end
        REG_STAGE2: stg_m <= reg_wdata[NDIV*MW-1:0];
        REG_SLOT: begin
          for (int s = 0; s < NSLOT; s++) begin
            stg_en[s] <= reg_wdata[s];
            stg_lp[s] <= reg_wdata[SLOT_LP_BASE+s];
            stg_sel[s*SELW +: SELW] <= reg_wdata[SLOT_SEL_BASE+s*SELW +: SELW];
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pending  <= 1'b0;
      lock_err <= 1'b0;
    end else begin
      if (commit) pending <= 1'b0;
      else if (start_req && !pending) pending <= 1'b1;
      if (start_req && pending) lock_err <= 1'b1;
      else if (ctrl_wr && reg_wdata[CTRL_LOCK_BIT]) lock_err <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_p   <= PW'(1);
      sh_h   <= '0;
      sh_m   <= '0;
      sh_en  <= '0;
      sh_lp  <= '0;
      sh_sel <= '0;
    end else if (commit) begin
      sh_p   <= eff_p;
      sh_h   <= eff_h;
      sh_m   <= stg_m;
      sh_en  <= stg_en;
      sh_lp  <= stg_lp;
      sh_sel <= stg_sel;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      REG_STAGE1: begin
        rd_mux[PW-1:0]    = stg_p;
        rd_mux[2*PW-1:PW] = stg_h;
      end
      REG_STAGE2: rd_mux[NDIV*MW-1:0] = stg_m;
      REG_SLOT: begin
        for (int s = 0; s < NSLOT; s++) begin
          rd_mux[s] = stg_en[s];
          rd_mux[SLOT_LP_BASE+s] = stg_lp[s];
          rd_mux[SLOT_SEL_BASE+s*SELW +: SELW] = stg_sel[s*SELW +: SELW];
        end
      end
      default: begin
        rd_mux[CTRL_START_BIT] = pending;
        rd_mux[CTRL_LOCK_BIT]  = lock_err;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/cclk_gen.sv
module cclk_gen #(
  parameter int NSLOT = 2,
  parameter int NDIV  = 4,
  parameter int PW    = 4,
  parameter int MW    = 8,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [1:0]       reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic [NSLOT-1:0] slot_busy,
  output logic [NSLOT-1:0] card_clk
);
  localparam int SELW = (NDIV > 1) ? $clog2(NDIV) : 1;

  logic                  commit, pending, lock_err, safe;
  logic [PW-1:0]         sh_p, sh_h;
  logic [NDIV*MW-1:0]    sh_m;
  logic [NSLOT-1:0]      sh_en, sh_lp;
  logic [NSLOT*SELW-1:0] sh_sel;
  logic                  clk1, s1_last;
  logic [NDIV-1:0]       div_vec, low_vec;
  logic [NSLOT-1:0]      src_vec;

  assign safe = s1_last & (&low_vec);

  cclk_regs #(
    .NSLOT(NSLOT), .NDIV(NDIV), .PW(PW), .MW(MW), .SELW(SELW), .DW(DW)
  ) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .safe(safe), .commit(commit), .pending(pending), .lock_err(lock_err),
    .sh_p(sh_p), .sh_h(sh_h), .sh_m(sh_m), .sh_en(sh_en), .sh_lp(sh_lp),
    .sh_sel(sh_sel)
  );

  cclk_stage1 #(.PW(PW)) u_stage1 (
    .clk(clk), .rst(rst), .per(sh_p), .high(sh_h), .clk1(clk1), .last(s1_last)
  );

  for (genvar k = 0; k < NDIV; k++) begin : g_div
    cclk_stage2 #(.MW(MW)) u_div (
      .clk(clk), .rst(rst), .rise(s1_last), .commit(commit),
      .m(sh_m[k*MW +: MW]), .clk1(clk1),
      .div(div_vec[k]), .low_ok(low_vec[k])
    );
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    cclk_slot_gate #(.NDIV(NDIV), .SELW(SELW)) u_gate (
      .clk(clk), .rst(rst), .div(div_vec), .sel(sh_sel[s*SELW +: SELW]),
      .en(sh_en[s]), .lp(sh_lp[s]), .busy(slot_busy[s]),
      .src(src_vec[s]), .card(card_clk[s])
    );
  end
endmodule

// File: rtl/cclk_gen_chk.sv
module cclk_gen_chk #(
  parameter int NSLOT = 2,
  parameter int DW    = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             commit,
  input logic             pending,
  input logic             lock_err,
  input logic             s1_last,
  input logic             clk1,
  input logic [NSLOT-1:0] src_vec,
  input logic [NSLOT-1:0] card_clk,
  input logic             reg_wr,
  input logic [1:0]       reg_addr,
  input logic [DW-1:0]    reg_wdata
);
  logic ctrl_wr;
  assign ctrl_wr = reg_wr && (reg_addr == 2'd3);

  AST_COMMIT_AT_LOW: assert property (@(posedge clk) disable iff (rst)
    commit |-> (s1_last && !clk1)); // R11
  AST_START_ACK: assert property (@(posedge clk) disable iff (rst)
    commit |=> !pending); // R7
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
    (lock_err && !(ctrl_wr && reg_wdata[1])) |=> lock_err); // R9
  AST_LOCK_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && reg_wdata[1] && !reg_wdata[0]) |=> !lock_err); // R10
  AST_BASE_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(clk1) |-> $past(s1_last)); // R1

  for (genvar s = 0; s < NSLOT; s++) begin : g_chk
    AST_CARD_FOLLOWS_SRC: assert property (@(posedge clk) disable iff (rst)
      $rose(card_clk[s]) |-> $past(src_vec[s])); // R11
  end
endmodule

bind cclk_gen cclk_gen_chk #(.NSLOT(NSLOT), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .commit(commit), .pending(pending),
  .lock_err(lock_err), .s1_last(s1_last), .clk1(clk1), .src_vec(src_vec),
  .card_clk(card_clk), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata)
);

// File: tb/tb_cclk_gen.sv
module tb_cclk_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [1:0]  slot_busy = '0;
  logic [1:0]  card_clk;

  int checks = 0, fails = 0;
  bit done = 0;

  cclk_gen dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .slot_busy(slot_busy), .card_clk(card_clk)
  );

  always #10 clk = ~clk;

  localparam int NV = 10;
  localparam logic [7:0]  V_S1  [NV] = '{8'h13, 8'h04, 8'h7F, 8'h01, 8'h00,
                                         8'h92, 8'h13, 8'h02, 8'h01, 8'h01};
  localparam logic [31:0] V_M   [NV] = '{32'h0, 32'h0, 32'h0, 32'h0, 32'h0,
                                         32'h0, 32'h0000_0200, 32'h0003_0000,
                                         32'h0100_0000, 32'h0000_0201};
  localparam logic [1:0]  V_SL0 [NV] = '{2'd0, 2'd0, 2'd0, 2'd0, 2'd0,
                                         2'd0, 2'd1, 2'd2, 2'd3, 2'd0};
  localparam logic [1:0]  V_SL1 [NV] = '{2'd1, 2'd0, 2'd0, 2'd0, 2'd0,
                                         2'd0, 2'd0, 2'd0, 2'd3, 2'd1};
  localparam int E_HI0 [NV] = '{2, 1, 8, 1, 1, 2, 8, 9, 2, 2};
  localparam int E_LO0 [NV] = '{2, 4, 8, 1, 1, 1, 8, 9, 2, 2};
  localparam int E_HI1 [NV] = '{2, 1, 8, 1, 1, 2, 2, 1, 2, 4};
  localparam int E_LO1 [NV] = '{2, 4, 8, 1, 1, 1, 2, 2, 2, 4};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic commit_cfg();
    logic [31:0] d;
    int n;
    wr(2'd3, 32'h1);
    rd(2'd3, d);
    chk(d[0] == 1'b1, "R7 pending after start", int'(d[0]), 1);
    n = 0;
    while (d[0] && n < 20000) begin rd(2'd3, d); n++; end
    chk(d[0] == 1'b0, "R7 start cleared", int'(d[0]), 0);
  endtask

  task automatic measure(input int s, output int hi, output int lo);
    int n;
    n = 0;
    while (card_clk[s] == 1'b1 && n < 5000) begin @(negedge clk); n++; end
    while (card_clk[s] == 1'b0 && n < 5000) begin @(negedge clk); n++; end
    hi = 0;
    while (card_clk[s] == 1'b1 && n < 5000) begin hi++; @(negedge clk); n++; end
    lo = 0;
    while (card_clk[s] == 1'b0 && n < 5000) begin lo++; @(negedge clk); n++; end
    if (n >= 5000) begin hi = -1; lo = -1; end
  endtask

  task automatic meas2(input int s, output int hi, output int lo);
    measure(s, hi, lo);
    measure(s, hi, lo);
  endtask

  task automatic count_high(input int s, input int cyc, output int nh);
    nh = 0;
    for (int i = 0; i < cyc; i++) begin
      if (card_clk[s]) nh++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R7 watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int hi, lo, nh;
    string t1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R12 reset state
    chk(card_clk == 2'b00, "R12 card clocks low", int'(card_clk), 0);
    rd(2'd3, d);
    chk(d == 32'h0, "R12 ctrl reset", int'(d), 0);
    rd(2'd0, d);
    chk(d == 32'h0, "R12 stage1 reset", int'(d), 0);

    // table walk: R1 R2 R3 R4
    for (int i = 0; i < NV; i++) begin
      wr(2'd0, {24'h0, V_S1[i]});
      wr(2'd1, V_M[i]);
      wr(2'd2, 32'h3 | (32'(V_SL0[i]) << 16) | (32'(V_SL1[i]) << 18));
      commit_cfg();
      meas2(0, hi, lo);
      chk(hi == E_HI0[i], (i < 6) ? "R1 slot0 high" : "R2 slot0 high", hi, E_HI0[i]);
      chk(lo == E_LO0[i], (i < 6) ? "R1 slot0 low" : "R2 slot0 low", lo, E_LO0[i]);
      t1 = (i == 0) ? "R3 slot1 bypass" : "R4 slot1 own source";
      meas2(1, hi, lo);
      chk(hi == E_HI1[i], t1, hi, E_HI1[i]);
      chk(lo == E_LO1[i], t1, lo, E_LO1[i]);
    end

    // R8 staged write without start has no effect
    wr(2'd0, 32'h3F);
    meas2(0, hi, lo);
    chk(hi == 2 && lo == 2, "R8 clock unchanged", hi, 2);
    rd(2'd0, d);
    chk(d == 32'h3F, "R8 staged readback", int'(d), 32'h3F);

    // R5 disable slot1
    wr(2'd0, 32'h01);
    wr(2'd1, 32'h0);
    wr(2'd2, 32'h1);
    commit_cfg();
    repeat (4) @(negedge clk);
    count_high(1, 100, nh);
    chk(nh == 0, "R5 disabled slot low", nh, 0);
    meas2(0, hi, lo);
    chk(hi == 1 && lo == 1, "R5 enabled slot runs", hi, 1);

    // R6 low power gating
    slot_busy = 2'b00;
    wr(2'd2, 32'h101);
    commit_cfg();
    repeat (4) @(negedge clk);
    count_high(0, 100, nh);
    chk(nh == 0, "R6 idle slot stopped", nh, 0);
    slot_busy = 2'b01;
    meas2(0, hi, lo);
    chk(hi == 1 && lo == 1, "R6 busy slot runs", hi, 1);
    slot_busy = 2'b00;
    repeat (4) @(negedge clk);
    count_high(0, 50, nh);
    chk(nh == 0, "R6 idle again stopped", nh, 0);

    // R9 lock error on second start while pending
    wr(2'd1, 32'h0000_0003);
    reg_wr = 1'b1; reg_addr = 2'd3; reg_wdata = 32'h1;
    @(negedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
    rd(2'd3, d);
    chk(d[1] == 1'b1, "R9 lock flag set", int'(d[1]), 1);
    for (int n = 0; n < 20000 && d[0]; n++) rd(2'd3, d);
    chk(d[0] == 1'b0, "R9 pending completes", int'(d[0]), 0);
    rd(2'd3, d);
    chk(d[1] == 1'b1, "R9 lock flag sticky", int'(d[1]), 1);

    // R10 write-one-to-clear
    wr(2'd3, 32'h2);
    rd(2'd3, d);
    chk(d == 32'h0, "R10 lock flag cleared", int'(d), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule